// File: doc/BRIEF.md
# Cascaded Interrupt Vector Unit

This block pairs two eight-line interrupt controllers. A secondary unit feeds the primary unit's line 2, and a single interrupt request goes to the processor. Each unit catches rising edges on its lines into a pending register. It picks a winner by fixed priority: line 0 is highest and line 7 is lowest. A unit only reports a winner to the stage above it when its "raised" flag is clear. Reporting sets the flag, and the flag stays set until the processor acknowledges. This stops the same request from being announced twice.

When the secondary unit reports, it drops a one-cycle pulse into the primary unit's line 2 pending bit. When the primary unit reports, it issues a one-cycle pulse on the processor interrupt output. A combinational vector output always shows the vector the processor would fetch now. If the primary winner is the cascade line, the vector comes from the secondary unit's base and winner. If there is no winner, line 7 stands in as a spurious vector. On acknowledge, the vector's upper bits pick which unit or units move the line from pending to in-service.

Mask, base, nesting mode and auto-end-of-interrupt settings arrive as plain inputs from the controllers' programming logic. A specific end-of-interrupt input clears one in-service bit.

Top module: `cascade_vector_top`

## Requirements
- R1: After reset, intr_o is 0, every pending, in-service and raised status is 0, and vec_o equals {base_m_i, 3'd7}.
- R2: A rising edge on an unmasked primary line sets its pending bit at the next edge. If that line then wins and the primary raised flag is clear, the flag sets and intr_o is high for exactly one cycle, starting two clock edges after the line rose.
- R3: While the primary raised flag is set, no new intr_o pulse is produced, even if a higher-priority line becomes pending.
- R4: A secondary winner, with the secondary raised flag clear, sets that flag and primary pending bit 2 at the same edge. intr_o then pulses one edge later. The primary input line 2 itself is ignored.
- R5: The primary winner is the lowest-index line that is pending, unmasked and not blocked. vec_o is {base_m_i, pin}.
- R6: When the primary winner is line 2, vec_o is {base_s_i, secondary winner}. If the secondary unit has no winner, vec_o is {base_s_i, 3'd7}.
- R7: With no primary winner, vec_o is {base_m_i, 3'd7}.
- R8: On ack_i, if ack_vec_i[7:3] equals base_s_i, the secondary unit accepts line ack_vec_i[2:0] and the primary unit accepts line 2. Otherwise the primary unit accepts line ack_vec_i[2:0]. Accepting clears that pending bit and the unit's raised flag, and sets the in-service bit.
- R9: An in-service bit blocks its own line and all lower-priority lines from winning. A masked line never wins.
- R10: With sfnm_i set, primary in-service bit 2 does not block primary arbitration, so new secondary requests reach intr_o.
- R11: With aeoi_i set, acceptance leaves the in-service bits unchanged.
- R12: eoi_i clears in-service bit eoi_pin_i of the secondary unit when eoi_slave_i is 1, and of the primary unit when it is 0. Arbitration then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_m_i | input | 8 | Primary request lines (bit 2 unused) |
| irq_s_i | input | 8 | Secondary request lines |
| mask_m_i | input | 8 | Primary mask, 1 = masked |
| mask_s_i | input | 8 | Secondary mask, 1 = masked |
| base_m_i | input | 5 | Primary vector base (upper five bits) |
| base_s_i | input | 5 | Secondary vector base (upper five bits) |
| sfnm_i | input | 1 | Special fully nested mode on the primary unit |
| aeoi_i | input | 1 | Automatic end of interrupt |
| ack_i | input | 1 | Processor acknowledge strobe |
| ack_vec_i | input | 8 | Vector being acknowledged |
| eoi_i | input | 1 | Specific end-of-interrupt strobe |
| eoi_slave_i | input | 1 | End-of-interrupt targets secondary unit |
| eoi_pin_i | input | 3 | Line whose in-service bit is cleared |
| intr_o | output | 1 | One-cycle processor interrupt pulse |
| vec_o | output | 8 | Current vector |
| req_m_o | output | 8 | Primary pending bits |
| isr_m_o | output | 8 | Primary in-service bits |
| raised_m_o | output | 1 | Primary raised flag |
| req_s_o | output | 8 | Secondary pending bits |
| isr_s_o | output | 8 | Secondary in-service bits |
| raised_s_o | output | 1 | Secondary raised flag |

## Verification
The hardest state to reach is a secondary request that arrives while the primary cascade line is already in service. The bench acknowledges one secondary interrupt, which leaves both in-service bits set. It then raises a higher-priority secondary line. Run once with nesting off and once with it on, this shows the request stalled at the primary unit in the first case and passing through in the second. A separate case masks all secondary lines after the cascade pulse to expose the secondary spurious vector.

// File: rtl/cascade_vector_pkg.sv
package cascade_vector_pkg;
  localparam int NUM_PINS  = 8;
  localparam int PIN_W     = $clog2(NUM_PINS);
  localparam int BASE_W    = 8 - PIN_W;
  localparam int CASC_PIN  = 2;
  localparam int SPUR_PIN  = NUM_PINS - 1;

  typedef struct packed {
    logic             valid;
    logic [PIN_W-1:0] pin;
  } win_t;

  // fixed priority, pin 0 highest; an in-service bit stops the scan
  function automatic win_t pick_win(logic [NUM_PINS-1:0] req,
                                    logic [NUM_PINS-1:0] mask,
                                    logic [NUM_PINS-1:0] blk);
    win_t w;
    logic done;
    w    = '0;
    done = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (!done) begin
        if (blk[i]) done = 1'b1;
        else if (req[i] && !mask[i]) begin
          w.valid = 1'b1;
          w.pin   = PIN_W'(i);
          done    = 1'b1;
        end
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/pic_unit.sv
module pic_unit
  import cascade_vector_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] line_i,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] bypass_i,
  input  logic                aeoi_i,
  input  logic                accept_i,
  input  logic [PIN_W-1:0]    accept_pin_i,
  input  logic                eoi_i,
  input  logic [PIN_W-1:0]    eoi_pin_i,
  output logic [NUM_PINS-1:0] req_o,
  output logic [NUM_PINS-1:0] isr_o,
  output logic                raised_o,
  output win_t                win_o,
  output logic                fire_o
);
  logic [NUM_PINS-1:0] line_q, req_q, isr_q;
  logic                raised_q;
  logic [NUM_PINS-1:0] acc_vec, eoi_vec, rise;

  assign rise    = line_i & ~line_q;
  assign acc_vec = accept_i ? (NUM_PINS'(1) << accept_pin_i) : '0;
  assign eoi_vec = eoi_i ? (NUM_PINS'(1) << eoi_pin_i) : '0;
  assign win_o   = pick_win(req_q, mask_i, isr_q & ~bypass_i);
  assign fire_o  = !raised_q && win_o.valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q   <= '0;
      req_q    <= '0;
      isr_q    <= '0;
      raised_q <= 1'b0;
    end else begin
      line_q <= line_i;
      req_q  <= (req_q & ~acc_vec) | rise | set_i;
      isr_q  <= (isr_q & ~eoi_vec) | (aeoi_i ? '0 : acc_vec);
      if (fire_o)        raised_q <= 1'b1;
      else if (accept_i) raised_q <= 1'b0;
    end
  end

  assign req_o    = req_q;
  assign isr_o    = isr_q;
  assign raised_o = raised_q;
endmodule

// File: rtl/vec_route.sv
module vec_route
  import cascade_vector_pkg::*;
(
  input  win_t              win_m_i,
  input  win_t              win_s_i,
  input  logic [BASE_W-1:0] base_m_i,
  input  logic [BASE_W-1:0] base_s_i,
  input  logic              ack_i,
  input  logic [7:0]        ack_vec_i,
  output logic [7:0]        vec_o,
  output logic              acc_m_o,
  output logic [PIN_W-1:0]  acc_m_pin_o,
  output logic              acc_s_o,
  output logic [PIN_W-1:0]  acc_s_pin_o
);
  logic             via_s, hit_s;
  logic [PIN_W-1:0] pin_m, pin_s;

  assign via_s = win_m_i.valid && (win_m_i.pin == PIN_W'(CASC_PIN));
  assign pin_m = win_m_i.valid ? win_m_i.pin : PIN_W'(SPUR_PIN);
  assign pin_s = win_s_i.valid ? win_s_i.pin : PIN_W'(SPUR_PIN);
  assign vec_o = via_s ? {base_s_i, pin_s} : {base_m_i, pin_m};

  assign hit_s       = ack_i && (ack_vec_i[7:PIN_W] == base_s_i);
  assign acc_s_o     = hit_s;
  assign acc_s_pin_o = ack_vec_i[PIN_W-1:0];
  assign acc_m_o     = ack_i;
  assign acc_m_pin_o = hit_s ? PIN_W'(CASC_PIN) : ack_vec_i[PIN_W-1:0];
endmodule

// File: rtl/cascade_vector_top.sv
module cascade_vector_top
  import cascade_vector_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  irq_m_i,
  input  logic [7:0]  irq_s_i,
  input  logic [7:0]  mask_m_i,
  input  logic [7:0]  mask_s_i,
  input  logic [4:0]  base_m_i,
  input  logic [4:0]  base_s_i,
  input  logic        sfnm_i,
  input  logic        aeoi_i,
  input  logic        ack_i,
  input  logic [7:0]  ack_vec_i,
  input  logic        eoi_i,
  input  logic        eoi_slave_i,
  input  logic [2:0]  eoi_pin_i,
  output logic        intr_o,
  output logic [7:0]  vec_o,
  output logic [7:0]  req_m_o,
  output logic [7:0]  isr_m_o,
  output logic        raised_m_o,
  output logic [7:0]  req_s_o,
  output logic [7:0]  isr_s_o,
  output logic        raised_s_o
);
  localparam logic [NUM_PINS-1:0] CASC_BIT = NUM_PINS'(1) << CASC_PIN;

  win_t             win_m, win_s;
  logic             fire_m, fire_s, intr_q;
  logic             acc_m, acc_s;
  logic [PIN_W-1:0] acc_m_pin, acc_s_pin;

  pic_unit u_sec (
    .clk_i, .rst_ni,
    .line_i       (irq_s_i),
    .set_i        ('0),
    .mask_i       (mask_s_i),
    .bypass_i     ('0),
    .aeoi_i,
    .accept_i     (acc_s),
    .accept_pin_i (acc_s_pin),
    .eoi_i        (eoi_i && eoi_slave_i),
    .eoi_pin_i,
    .req_o        (req_s_o),
    .isr_o        (isr_s_o),
    .raised_o     (raised_s_o),
    .win_o        (win_s),
    .fire_o       (fire_s)
  );

  // secondary report drops straight into the cascade pending bit
  pic_unit u_pri (
    .clk_i, .rst_ni,
    .line_i       (irq_m_i & ~CASC_BIT),
    .set_i        (fire_s ? CASC_BIT : '0),
    .mask_i       (mask_m_i),
    .bypass_i     (sfnm_i ? CASC_BIT : '0),
    .aeoi_i,
    .accept_i     (acc_m),
    .accept_pin_i (acc_m_pin),
    .eoi_i        (eoi_i && !eoi_slave_i),
    .eoi_pin_i,
    .req_o        (req_m_o),
    .isr_o        (isr_m_o),
    .raised_o     (raised_m_o),
    .win_o        (win_m),
    .fire_o       (fire_m)
  );

  vec_route u_route (
    .win_m_i     (win_m),
    .win_s_i     (win_s),
    .base_m_i,
    .base_s_i,
    .ack_i,
    .ack_vec_i,
    .vec_o,
    .acc_m_o     (acc_m),
    .acc_m_pin_o (acc_m_pin),
    .acc_s_o     (acc_s),
    .acc_s_pin_o (acc_s_pin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) intr_q <= 1'b0;
    else         intr_q <= fire_m;
  end

  assign intr_o = intr_q;
endmodule

// File: rtl/cascade_vector_chk.sv
module cascade_vector_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] irq_m_i,
  input logic [7:0] irq_s_i,
  input logic [7:0] mask_m_i,
  input logic [7:0] mask_s_i,
  input logic [4:0] base_m_i,
  input logic [4:0] base_s_i,
  input logic       sfnm_i,
  input logic       aeoi_i,
  input logic       ack_i,
  input logic [7:0] ack_vec_i,
  input logic       eoi_i,
  input logic       eoi_slave_i,
  input logic [2:0] eoi_pin_i,
  input logic       intr_o,
  input logic [7:0] vec_o,
  input logic [7:0] req_m_o,
  input logic [7:0] isr_m_o,
  input logic       raised_m_o,
  input logic [7:0] req_s_o,
  input logic [7:0] isr_s_o,
  input logic       raised_s_o
);
  p_intr_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |=> !intr_o);

  p_intr_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> raised_m_o);

  p_no_dup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raised_m_o |=> !intr_o);

  p_cascade_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raised_s_o) |-> req_m_o[2]);

  p_spurious_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_m_o & ~mask_m_i) == 8'h00) |-> (vec_o == {base_m_i, 3'd7}));

  p_aeoi_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && aeoi_i && !eoi_i) |=> (isr_m_o == $past(isr_m_o)));
endmodule

bind cascade_vector_top cascade_vector_chk u_chk (.*);

// File: tb/tb_cascade_vector_top.sv
`timescale 1ns/1ps
module tb_cascade_vector_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] irq_m_i, irq_s_i, mask_m_i, mask_s_i, ack_vec_i;
  logic [4:0] base_m_i, base_s_i;
  logic       sfnm_i, aeoi_i, ack_i, eoi_i, eoi_slave_i;
  logic [2:0] eoi_pin_i;
  logic       intr_o, raised_m_o, raised_s_o;
  logic [7:0] vec_o, req_m_o, isr_m_o, req_s_o, isr_s_o;

  int total = 0;
  int bad   = 0;

  localparam logic [4:0] BM = 5'h08;  // vectors 0x40..0x47
  localparam logic [4:0] BS = 5'h0E;  // vectors 0x70..0x77

  always #2.5 clk_i = ~clk_i;

  cascade_vector_top dut (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic sfnm, input logic aeoi);
    rst_ni = 1'b0;
    irq_m_i = '0; irq_s_i = '0; mask_m_i = '0; mask_s_i = '0;
    base_m_i = BM; base_s_i = BS; sfnm_i = sfnm; aeoi_i = aeoi;
    ack_i = 1'b0; ack_vec_i = '0; eoi_i = 1'b0; eoi_slave_i = 1'b0; eoi_pin_i = '0;
    step(); step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic count_intr(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (intr_o) c++;
    end
  endtask

  task automatic ack(input logic [7:0] v);
    ack_i = 1'b1; ack_vec_i = v;
    step();
    ack_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    chk("R1 intr", intr_o, 0);
    chk("R1 status", {req_m_o, isr_m_o, req_s_o, isr_s_o, raised_m_o, raised_s_o}, 0);
    chk("R1 vec", vec_o, 8'h47);
  endtask

  task automatic t_master();
    int c;
    do_reset(1'b0, 1'b0);
    irq_m_i[3] = 1'b1;
    step();
    chk("R2 req", req_m_o, 8'h08);
    chk("R5 vec pin3", vec_o, 8'h43);
    chk("R2 no intr yet", intr_o, 0);
    step();
    chk("R2 intr high", intr_o, 1);
    chk("R2 raised", raised_m_o, 1);
    step();
    chk("R2 intr one cycle", intr_o, 0);
    irq_m_i[1] = 1'b1;
    count_intr(4, c);
    chk("R3 no duplicate", c, 0);
    chk("R5 vec priority", vec_o, 8'h41);
    ack(8'h41);
    chk("R8 isr", isr_m_o, 8'h02);
    chk("R8 req", req_m_o, 8'h08);
    chk("R8 raised clr", raised_m_o, 0);
    count_intr(3, c);
    chk("R9 blocked", c, 0);
    chk("R7 spurious", vec_o, 8'h47);
    eoi_i = 1'b1; eoi_pin_i = 3'd1; eoi_slave_i = 1'b0;
    step();
    eoi_i = 1'b0;
    chk("R12 isr clr", isr_m_o, 0);
    count_intr(3, c);
    chk("R12 resumes", c, 1);
  endtask

  task automatic t_mask();
    int c;
    do_reset(1'b0, 1'b0);
    mask_m_i = 8'h01;
    irq_m_i[0] = 1'b1;
    count_intr(4, c);
    chk("R9 masked req", req_m_o, 8'h01);
    chk("R9 masked no intr", c, 0);
    chk("R7 masked vec", vec_o, 8'h47);
  endtask

  task automatic t_slave(input logic sfnm);
    int c;
    do_reset(sfnm, 1'b0);
    irq_s_i[5] = 1'b1;
    irq_m_i[2] = 1'b1;  // cascade line input must be ignored
    step();
    chk("R4 sreq", req_s_o, 8'h20);
    chk("R4 mreq2 ignored", req_m_o, 8'h00);
    step();
    chk("R4 sraised", raised_s_o, 1);
    chk("R4 cascade bit", req_m_o, 8'h04);
    chk("R4 intr not yet", intr_o, 0);
    step();
    chk("R4 intr", intr_o, 1);
    chk("R6 vec via slave", vec_o, 8'h75);
    ack(8'h75);
    chk("R8 sisr", isr_s_o, 8'h20);
    chk("R8 misr", isr_m_o, 8'h04);
    chk("R8 reqs clr", {req_s_o, req_m_o}, 0);
    chk("R8 flags clr", {raised_s_o, raised_m_o}, 0);
    irq_s_i[1] = 1'b1;
    count_intr(5, c);
    chk("R4 sraised again", raised_s_o, 1);
    chk("R4 cascade again", req_m_o[2], 1);
    if (!sfnm) begin
      chk("R9 cascade blocked", c, 0);
      chk("R9 vec blocked", vec_o, 8'h47);
    end else begin
      chk("R10 nested passes", c, 1);
      chk("R10 vec", vec_o, 8'h71);
    end
  endtask

  task automatic t_slave_spur();
    do_reset(1'b0, 1'b0);
    irq_s_i[4] = 1'b1;
    step(); step();
    chk("R6 setup", raised_s_o, 1);
    mask_s_i = 8'hFF;
    #1;
    chk("R6 slave spurious", vec_o, 8'h77);
  endtask

  task automatic t_aeoi();
    int c;
    do_reset(1'b0, 1'b1);
    irq_m_i[6] = 1'b1;
    count_intr(3, c);
    chk("R11 intr", c, 1);
    ack(8'h46);
    chk("R11 isr untouched", isr_m_o, 0);
    chk("R11 req clr", req_m_o, 0);
    chk("R11 raised clr", raised_m_o, 0);
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_master();
    t_mask();
    t_slave(1'b0);
    t_slave(1'b1);
    t_slave_spur();
    t_aeoi();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule